// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block is the interrupt unit of a small 8-bit processor. Six level-sensitive event inputs each feed a pending flag. Firmware can read the pending flags and clear them with a write-one-to-clear mask. Each source also has an enable bit, and firmware writes all six enable bits as one register. All sources share a single vector. The hardware applies no priority between sources, so the service routine reads the pending flags to decide what to handle first.

The core raises a strobe when an instruction completes. On that strobe, if no service is in progress and any pending source is also enabled, the block asks the core to insert a call to the vector address in the same cycle. From the next cycle an in-service flag is set, and it refuses further requests. The core signals a return-from-interrupt by raising the return strobe together with the boundary strobe of that instruction. The flag clears on that edge, so the earliest new acceptance is at the end of the next instruction. At least one main-program instruction therefore always runs between two services.

Top module: `irq_unit`

## Requirements
- R1: A synchronous active-low reset clears every pending flag, every enable bit and the in-service flag, and no call request is raised while they are clear.
- R2: A high level on event input i sets pending flag i on the next clock edge, whatever the value of enable bit i.
- R3: A pending flag stays set until a clear mask with a 1 in bit i is applied while event i is low. Bits of the mask that are 0 leave their flags unchanged.
- R4: When event i is high in the same cycle as a clear of bit i, the event wins and flag i stays set.
- R5: A cycle with the enable-write strobe high replaces all six enable bits with the write data. The bits read back on the enable output on the next cycle and hold until the next write.
- R6: The call request is high in the same cycle exactly when the boundary strobe is high, the in-service flag is clear, and the bitwise AND of the pending and enable flags is non-zero.
- R7: While the call request is high the vector output equals 0x001. Otherwise the vector output is zero.
- R8: A call request sets the in-service flag on the next edge. While the flag is set no call request is raised.
- R9: The return strobe together with the boundary strobe, while in service, clears the flag on that edge. No request is raised at that boundary, and a request is possible again at the next boundary.
- R10: A return strobe without the boundary strobe, or while the in-service flag is clear, changes nothing.
- R11: Each of the six sources, enabled alone, produces the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 6 | Level-sensitive event per source |
| clr_mask_i | input | 6 | Write-one-to-clear mask for pending flags |
| en_we_i | input | 1 | Enable-register write strobe |
| en_wdata_i | input | 6 | New enable bits |
| instr_end_i | input | 1 | Instruction completes this cycle |
| reti_i | input | 1 | Completing instruction is a return-from-interrupt |
| pend_o | output | 6 | Pending flags |
| en_o | output | 6 | Enable bits |
| insvc_o | output | 1 | In-service flag |
| call_req_o | output | 1 | Insert a call to the vector now |
| call_vec_o | output | 12 | Vector address while requesting, else zero |

## Verification
A wrong pending flag shows up on the pending output one edge after the stimulus. When that source is enabled, it also shows up as a missing or extra call request at the next boundary strobe. A stuck or early-cleared in-service flag is visible at the following boundary: either a second request appears during service, or no request appears after the return plus one instruction. The sweep runs every enable mask against every single source and follows each accepted request through its return. A fault in the combination logic or the nesting lock therefore shows within a few cycles of the pattern that exposes it.

// File: rtl/irq_pkg.sv
// Package: shared sizes and the sequencer state type for the interrupt unit.
// Assumes one vector and a small number of sources (fits in one word).
package irq_pkg;
    parameter int          IRQ_SRC_CNT = 6;
    parameter int          IRQ_ADDR_W  = 12;
    parameter logic [11:0] IRQ_VECTOR  = 12'h001;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;
endpackage

// File: rtl/irq_pend_bank.sv
// Pending-flag bank: one sticky flag per source, set by a level event,
// cleared by a write-one mask. Assumes set has priority over clear.
module irq_pend_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_flag
            logic flag_q;

            // Sticky flag: a new event beats a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q <= 1'b0;
                else        flag_q <= evt_i[g] | (flag_q & ~clr_i[g]);
            end

            assign pend_o[g] = flag_q;

            AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                evt_i[g] |=> pend_o[g]);                               // R2
            AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o[g] && !clr_i[g]) |=> pend_o[g]);               // R3
            AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !evt_i[g]) |=> !pend_o[g]);               // R3
            AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && evt_i[g]) |=> pend_o[g]);                 // R4
        end
    endgenerate
endmodule

// File: rtl/irq_enable_reg.sv
// Enable register: all bits replaced together on a write strobe.
// Assumes firmware always writes the full mask.
module irq_enable_reg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] en_o
);
    logic [N-1:0] en_q;

    // Whole-register write on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= '0;
        else if (we_i) en_q <= wdata_i;
    end

    assign en_o = en_q;

    AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (en_o == $past(wdata_i)));                            // R5
    AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(en_o));                                      // R5
endmodule

// File: rtl/irq_service_seq.sv
// Service sequencer: decides acceptance at instruction boundaries and
// keeps the in-service flag that blocks nesting. Assumes the core raises
// reti_i together with boundary_i on the completing return instruction.
module irq_service_seq #(
    parameter int          N      = 6,
    parameter int          ADDR_W = 12,
    parameter logic [11:0] VECTOR = 12'h001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      active_i,
    input  logic              boundary_i,
    input  logic              reti_i,
    output logic              call_req_o,
    output logic [ADDR_W-1:0] call_vec_o,
    output logic              insvc_o
);
    import irq_pkg::*;

    localparam logic [ADDR_W-1:0] VEC_W = ADDR_W'(VECTOR);

    seq_state_e state_q, state_d;
    logic       any_active;
    logic       accept;
    logic       release_ev;

    // Acceptance and release conditions.
    always_comb begin
        any_active = |active_i;
        accept     = boundary_i && (state_q == SEQ_IDLE) && any_active;
        release_ev = boundary_i && reti_i && (state_q == SEQ_BUSY);
    end

    // Next-state selection for the in-service flag.
    always_comb begin
        state_d = state_q;
        if (accept)          state_d = SEQ_BUSY;
        else if (release_ev) state_d = SEQ_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign call_req_o = accept;
    assign call_vec_o = accept ? VEC_W : '0;
    assign insvc_o    = (state_q == SEQ_BUSY);

    AST_REQ_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> boundary_i);                                    // R6
    AST_VEC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> (call_vec_o == VEC_W));                         // R7
    AST_ACCEPT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |=> insvc_o);                                       // R8
    AST_NO_NESTING: assert property (@(posedge clk) disable iff (!rst_n)
        insvc_o |-> !call_req_o);                                      // R8
    AST_RETI_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_o && reti_i && boundary_i) |=> !insvc_o);               // R9
    AST_RETI_MIDINSTR: assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_o && !boundary_i) |=> insvc_o);                         // R10
endmodule

// File: rtl/irq_unit.sv
// Interrupt unit top: pending bank, enable register and service sequencer.
// Assumes events are synchronous to clk and level-held by their sources.
module irq_unit #(
    parameter int          N_SRC  = irq_pkg::IRQ_SRC_CNT,
    parameter int          ADDR_W = irq_pkg::IRQ_ADDR_W,
    parameter logic [11:0] VECTOR = irq_pkg::IRQ_VECTOR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  evt_i,
    input  logic [N_SRC-1:0]  clr_mask_i,
    input  logic              en_we_i,
    input  logic [N_SRC-1:0]  en_wdata_i,
    input  logic              instr_end_i,
    input  logic              reti_i,
    output logic [N_SRC-1:0]  pend_o,
    output logic [N_SRC-1:0]  en_o,
    output logic              insvc_o,
    output logic              call_req_o,
    output logic [ADDR_W-1:0] call_vec_o
);
    logic [N_SRC-1:0] active;

    irq_pend_bank #(.N(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .clr_i  (clr_mask_i),
        .pend_o (pend_o)
    );

    irq_enable_reg #(.N(N_SRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (en_we_i),
        .wdata_i (en_wdata_i),
        .en_o    (en_o)
    );

    // Sources that may request service.
    assign active = pend_o & en_o;

    irq_service_seq #(.N(N_SRC), .ADDR_W(ADDR_W), .VECTOR(VECTOR)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .boundary_i (instr_end_i),
        .reti_i     (reti_i),
        .call_req_o (call_req_o),
        .call_vec_o (call_vec_o),
        .insvc_o    (insvc_o)
    );

    AST_REQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> ((pend_o & en_o) != '0));                       // R6
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pend_o == '0 && en_o == '0 && !insvc_o));          // R1
endmodule

// File: tb/irq_unit_tb.sv
// Bench: sweeps every enable mask against every single source, then
// directed corner cases. Inputs change on the falling edge.
module irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  evt, clr, en_wd, pend, en;
    logic        en_we, iend, reti, insvc, creq;
    logic [11:0] cvec;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #4 clk = ~clk;

    irq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_mask_i(clr),
        .en_we_i(en_we), .en_wdata_i(en_wd), .instr_end_i(iend),
        .reti_i(reti), .pend_o(pend), .en_o(en), .insvc_o(insvc),
        .call_req_o(creq), .call_vec_o(cvec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1600000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; evt = '0; clr = '0; en_wd = '0; en_we = 1'b0;
        iend = 1'b0; reti = 1'b0;
        @(negedge clk);
        evt = 6'h3F; en_we = 1'b1; en_wd = 6'h3F;
        tick(); tick();
        evt = '0; en_we = 1'b0;
        tick();
        iend = 1'b1; #1;
        chk("R1 pend", pend, 0);
        chk("R1 en", en, 0);
        chk("R1 insvc", insvc, 0);
        chk("R1 creq", creq, 0);
        iend = 1'b0;
        rst_n = 1'b1;
        tick();

        // Sweep every enable mask against every single source.
        for (int m = 0; m < 64; m++) begin
            for (int s = 0; s < 6; s++) begin
                logic hit;
                hit = m[s];
                en_we = 1'b1; en_wd = m[5:0];
                tick();
                en_we = 1'b0; en_wd = '0;
                chk("R5 enable readback", en, m);
                evt = 6'(1 << s);
                tick();
                evt = '0;
                chk("R2 event sets flag", pend, 1 << s);
                tick();
                chk("R3 flag holds", pend, 1 << s);
                iend = 1'b1; #1;
                chk("R6 request", creq, hit);
                chk("R7 R11 vector", cvec, hit ? 12'h001 : 12'h000);
                tick();
                iend = 1'b0;
                chk("R8 insvc set", insvc, hit);
                if (hit) begin
                    iend = 1'b1; #1;
                    chk("R8 nesting blocked", creq, 0);
                    tick();
                    reti = 1'b1; #1;
                    chk("R9 no request at return", creq, 0);
                    tick();
                    reti = 1'b0; #1;
                    chk("R9 flag released", insvc, 0);
                    chk("R9 next boundary accepts", creq, 1);
                    tick();
                    reti = 1'b1;
                    tick();
                    iend = 1'b0; reti = 1'b0;
                    chk("R9 released again", insvc, 0);
                end
                clr = 6'(1 << s);
                tick();
                clr = '0;
                chk("R3 clear", pend, 0);
            end
        end

        // Partial clear leaves other flags alone.
        evt = 6'h3F; tick(); evt = '0;
        clr = 6'h05; tick(); clr = '0;
        chk("R3 partial clear", pend, 6'h3A);
        // Event beats clear on the same edge.
        evt = 6'h08; clr = 6'h3F; tick(); evt = '0; clr = '0;
        chk("R4 event wins", pend, 6'h08);
        clr = 6'h3F; tick(); clr = '0;
        chk("R3 all clear", pend, 0);

        // Return strobe without boundary leaves the flag set.
        en_we = 1'b1; en_wd = 6'h3F; tick(); en_we = 1'b0;
        evt = 6'h20; tick(); evt = '0;
        iend = 1'b1; tick(); iend = 1'b0;
        chk("R8 accepted", insvc, 1);
        reti = 1'b1; tick(); reti = 1'b0;
        chk("R10 mid-instruction return ignored", insvc, 1);
        clr = 6'h3F; iend = 1'b1; reti = 1'b1; tick();
        clr = '0; iend = 1'b0; reti = 1'b0;
        chk("R9 cleared", insvc, 0);
        // Return while idle changes nothing.
        en_we = 1'b1; en_wd = 6'h00; tick(); en_we = 1'b0;
        evt = 6'h01; tick(); evt = '0;
        iend = 1'b1; reti = 1'b1; #1;
        chk("R6 disabled no request", creq, 0);
        tick(); iend = 1'b0; reti = 1'b0;
        chk("R10 idle return insvc", insvc, 0);
        chk("R10 idle return pend", pend, 6'h01);
        en_we = 1'b1; en_wd = 6'h01; tick(); en_we = 1'b0;
        iend = 1'b1; #1;
        chk("R10 acceptance still possible", creq, 1);
        tick(); iend = 1'b0;
        summary();
    end
endmodule